// File: doc/BRIEF.md
# Core Idle-State Sequencer

This controller follows one processor core through its idle depths: active (C0), halt (C1), the snoop-only state C2, and the clock-stopped states C3 and C4. While the core is active it takes entry requests in three forms: a halt, a wait instruction carrying a target-depth hint, or a read of one of the level registers. It then moves the core to the requested depth. It decides which events bring the core back to C0 in each depth, and it steps the core in and out of a snoop-service sub-state while in C2.

Before the clocks stop in C3 or C4, the core must write its first-level cache back into the second-level cache. The sequencer therefore raises a flush request and waits for an acknowledge. A wake event that arrives during the flush cancels the entry.

In C4 the core also marks itself as eligible for the deepest package sleep. A synchronous core reset returns the core to C0 from any state.

Top module: `core_idle_fsm`

## Requirements
- R1: After `rst_n` is released, `state_oh` is 5'b00001 (C0), and `flush_req`, `clk_stop`, `snoop_svc` and `pkg_deep_ok` are all 0.
- R2: In C0, an entry request moves the core after the next clock edge. The request forms are:
  - `halt_req`, or `mwait_req` with `mwait_hint`=1, enters C1.
  - `mwait_hint`=2 or `lvl_rd_idx`=2 enters C2.
  - A value of 3 or 4 in either field starts the flush for C3 or C4.
  - A level read with any other index is ignored.
- R3: In C1, `wake_smi`, `wake_init`, either bit of `wake_lint`, or `wake_busint` returns the core to C0. `monitor_hit` wakes the core only if C1 was entered through `mwait_req` and the monitor is armed. In halt-entered C1, `monitor_hit` leaves the state unchanged.
- R4: In C2, `snoop_req` sets `snoop_svc` while `state_oh` stays on C2. The core stays in service, and ignores wakes, until `snoop_done` returns it to plain C2. In plain C2 a wake returns the core to C0, and the wake wins over a simultaneous `snoop_req`.
- R5: During a C3/C4 entry, `flush_req` is 1 and `state_oh` shows C0 until `flush_ack`. After the edge that samples `flush_ack`, the core is in C3 or C4.
- R6: A wake during the flush returns the core to C0 and drops `flush_req`, even when `flush_ack` arrives in the same cycle.
- R7: In C3 and C4, `clk_stop` is 1 and `snoop_req` is ignored: the state is kept and `snoop_svc` stays 0.
- R8: In C3 and C4, any of the wake inputs returns the core to C0. `monitor_hit` counts as a wake only while the monitor is armed. The monitor is armed by `monitor_arm`, stays armed across the stay in C3 or C4, and is disarmed by a `monitor_hit`.
- R9: `pkg_deep_ok` is 1 exactly in C4, where `state_oh` is 5'b10000.
- R10: `core_reset` moves the core to C0 after the next edge from any state. It overrides wakes, `flush_ack` and requests, and it disarms the monitor.
- R11: `state_oh` always has exactly one bit set, where bit i is state Ci. `clk_stop` is 1 only in C3 or C4.
- R12: Entry requests are ignored outside C0. When several requests arrive together, a valid level read takes priority over a valid wait hint, and a valid wait hint takes priority over a halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_reset | input | 1 | Synchronous core reset event |
| halt_req | input | 1 | Halt entry request |
| mwait_req | input | 1 | Wait-instruction entry request |
| mwait_hint | input | 3 | Target depth of the wait instruction (1 to 4) |
| lvl_rd_req | input | 1 | Level-register read request |
| lvl_rd_idx | input | 3 | Index of the level register that was read (2 to 4) |
| monitor_arm | input | 1 | Arms the address monitor |
| monitor_hit | input | 1 | Monitor event |
| wake_smi | input | 1 | System-management interrupt |
| wake_init | input | 1 | Init request |
| wake_lint | input | 2 | Local interrupt lines |
| wake_busint | input | 1 | Bus interrupt message |
| snoop_req | input | 1 | Snoop to be serviced |
| snoop_done | input | 1 | Snoop service complete |
| flush_ack | input | 1 | Cache flush complete |
| state_oh | output | 5 | One-hot idle state, bit i = Ci |
| flush_req | output | 1 | Cache flush request |
| clk_stop | output | 1 | Core clock-stop enable |
| snoop_svc | output | 1 | Snoop service in progress |
| pkg_deep_ok | output | 1 | Core eligible for deepest package sleep |

## Verification
Each depth is entered in several ways: by halt, by wait hint, and by level read, including an invalid index. This separates the request decoding from the depth behaviour. The same wake and snoop inputs are then applied in C1, C2, C3 and C4, which shows that snoops are serviced only in C2 and that the monitor wakes the core only when armed, and in C1 only after a wait-instruction entry.

Flush acknowledges are sent alone, together with a wake, and together with a core reset. These patterns separate a completed entry from an aborted one and show that reset has top priority. Requests that collide, or that arrive outside C0, check the entry priority.

// File: rtl/core_idle_fsm.sv
module core_idle_fsm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       core_reset,
  input  logic       halt_req,
  input  logic       mwait_req,
  input  logic [2:0] mwait_hint,
  input  logic       lvl_rd_req,
  input  logic [2:0] lvl_rd_idx,
  input  logic       monitor_arm,
  input  logic       monitor_hit,
  input  logic       wake_smi,
  input  logic       wake_init,
  input  logic [1:0] wake_lint,
  input  logic       wake_busint,
  input  logic       snoop_req,
  input  logic       snoop_done,
  input  logic       flush_ack,
  output logic [4:0] state_oh,
  output logic       flush_req,
  output logic       clk_stop,
  output logic       snoop_svc,
  output logic       pkg_deep_ok
);

  typedef enum logic [2:0] {S_C0, S_C1, S_C2, S_SNP, S_FL, S_C3, S_C4} st_t;

  st_t        st, st_nx;
  logic       to_c4_q, to_c4_nx;
  logic       mw_c1_q, mw_c1_nx;
  logic       armed_q;
  logic [2:0] req_lvl;
  logic       req_mw;

  wire ext_wake = wake_smi | wake_init | (|wake_lint) | wake_busint;
  wire mon_wake = monitor_hit & armed_q;
  wire any_wake = ext_wake | mon_wake;

  always_comb begin
    req_lvl = 3'd0;
    req_mw  = 1'b0;
    if (lvl_rd_req && lvl_rd_idx >= 3'd2 && lvl_rd_idx <= 3'd4)
      req_lvl = lvl_rd_idx;
    else if (mwait_req && mwait_hint >= 3'd1 && mwait_hint <= 3'd4) begin
      req_lvl = mwait_hint;
      req_mw  = 1'b1;
    end else if (halt_req)
      req_lvl = 3'd1;
  end

  always_comb begin
    st_nx    = st;
    to_c4_nx = to_c4_q;
    mw_c1_nx = mw_c1_q;
    unique case (st)
      S_C0: begin
        case (req_lvl)
          3'd1: begin st_nx = S_C1; mw_c1_nx = req_mw; end
          3'd2: st_nx = S_C2;
          3'd3: begin st_nx = S_FL; to_c4_nx = 1'b0; end
          3'd4: begin st_nx = S_FL; to_c4_nx = 1'b1; end
          default: ;
        endcase
      end
      S_C1:  if (ext_wake || (mw_c1_q && mon_wake)) st_nx = S_C0;
      S_C2: begin
        if (any_wake)       st_nx = S_C0;
        else if (snoop_req) st_nx = S_SNP;
      end
      S_SNP: if (snoop_done) st_nx = S_C2;
      S_FL: begin
        if (any_wake)       st_nx = S_C0;
        else if (flush_ack) st_nx = to_c4_q ? S_C4 : S_C3;
      end
      S_C3, S_C4: if (any_wake) st_nx = S_C0;
      default: st_nx = S_C0;
    endcase
    if (core_reset) st_nx = S_C0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_C0;
      to_c4_q <= 1'b0;
      mw_c1_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      st      <= st_nx;
      to_c4_q <= to_c4_nx;
      mw_c1_q <= mw_c1_nx;
      if (core_reset)       armed_q <= 1'b0;
      else if (monitor_arm) armed_q <= 1'b1;
      else if (monitor_hit) armed_q <= 1'b0;
    end
  end

  assign state_oh[0]  = (st == S_C0) || (st == S_FL);
  assign state_oh[1]  = (st == S_C1);
  assign state_oh[2]  = (st == S_C2) || (st == S_SNP);
  assign state_oh[3]  = (st == S_C3);
  assign state_oh[4]  = (st == S_C4);
  assign flush_req    = (st == S_FL);
  assign clk_stop     = (st == S_C3) || (st == S_C4);
  assign snoop_svc    = (st == S_SNP);
  assign pkg_deep_ok  = (st == S_C4);

endmodule

// File: rtl/core_idle_fsm_chk.sv
module core_idle_fsm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       core_reset,
  input logic       monitor_hit,
  input logic       wake_smi,
  input logic       wake_init,
  input logic [1:0] wake_lint,
  input logic       wake_busint,
  input logic       snoop_req,
  input logic       snoop_done,
  input logic       flush_ack,
  input logic [4:0] state_oh,
  input logic       flush_req,
  input logic       clk_stop,
  input logic       snoop_svc,
  input logic       pkg_deep_ok
);

  wire quiet = !wake_smi && !wake_init && (wake_lint == 2'b00) && !wake_busint && !monitor_hit;

  a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state_oh) == 1);

  a_r11_clk_stop_deep: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stop |-> (state_oh[3] || state_oh[4]));

  a_r10_reset_to_c0: assert property (@(posedge clk) disable iff (!rst_n)
    core_reset |=> (state_oh == 5'b00001 && !flush_req && !snoop_svc));

  a_r7_snoop_kept_deep: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_stop && snoop_req && quiet && !core_reset) |=> (clk_stop && !snoop_svc && $stable(state_oh)));

  a_r5_flush_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && !flush_ack && quiet && !core_reset) |=> flush_req);

  a_r6_flush_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && !quiet && !core_reset) |=> (state_oh == 5'b00001 && !flush_req));

  a_r4_snoop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_svc && !snoop_done && !core_reset) |=> snoop_svc);

  a_r9_pkg_in_c4: assert property (@(posedge clk) disable iff (!rst_n)
    pkg_deep_ok |-> (clk_stop && state_oh[4]));

endmodule

bind core_idle_fsm core_idle_fsm_chk u_chk (.*);

// File: tb/tb_core_idle_fsm.sv
`timescale 1ns/1ps
module tb_core_idle_fsm;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic core_reset, halt_req, mwait_req, lvl_rd_req, monitor_arm, monitor_hit;
  logic wake_smi, wake_init, wake_busint, snoop_req, snoop_done, flush_ack;
  logic [2:0] mwait_hint, lvl_rd_idx;
  logic [1:0] wake_lint;
  logic [4:0] state_oh;
  logic flush_req, clk_stop, snoop_svc, pkg_deep_ok;

  always #5 clk = ~clk;

  core_idle_fsm dut (.*);

  localparam logic [8:0] E_C0  = {5'b00001, 4'b0000};
  localparam logic [8:0] E_C1  = {5'b00010, 4'b0000};
  localparam logic [8:0] E_C2  = {5'b00100, 4'b0000};
  localparam logic [8:0] E_SNP = {5'b00100, 4'b0010};
  localparam logic [8:0] E_FL  = {5'b00001, 4'b1000};
  localparam logic [8:0] E_C3  = {5'b01000, 4'b0100};
  localparam logic [8:0] E_C4  = {5'b10000, 4'b0101};

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [8:0] exp_q[$];
  int         req_q[$];

  wire [8:0] act = {state_oh, flush_req, clk_stop, snoop_svc, pkg_deep_ok};

  task automatic clear_in();
    core_reset = 0; halt_req = 0; mwait_req = 0; mwait_hint = 0;
    lvl_rd_req = 0; lvl_rd_idx = 0; monitor_arm = 0; monitor_hit = 0;
    wake_smi = 0; wake_init = 0; wake_lint = 0; wake_busint = 0;
    snoop_req = 0; snoop_done = 0; flush_ack = 0;
  endtask

  task automatic cyc(input logic [8:0] e, input int r);
    exp_q.push_back(e);
    req_q.push_back(r);
    @(negedge clk);
    clear_in();
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [8:0] e;
      int r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      n_cmp++;
      if (act !== e) begin
        n_bad++;
        $display("FAIL R%0d: got %b expected %b", r, act, e);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    clear_in();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    n_cmp++;
    if (act !== E_C0) begin n_bad++; $display("FAIL R1: got %b expected %b", act, E_C0); end
    @(negedge clk);
    cyc(E_C0, 1);                                                   // R1 idle hold

    halt_req = 1;                          cyc(E_C1, 2);            // R2
    wake_smi = 1;                          cyc(E_C0, 3);            // R3
    lvl_rd_req = 1; lvl_rd_idx = 5;        cyc(E_C0, 2);            // R2 invalid index
    mwait_req = 1; mwait_hint = 1;         cyc(E_C1, 2);            // R2
    monitor_hit = 1;                       cyc(E_C1, 3);            // R3 unarmed
    wake_lint = 2'b10;                     cyc(E_C0, 3);            // R3
    monitor_arm = 1;                       cyc(E_C0, 8);
    mwait_req = 1; mwait_hint = 1;         cyc(E_C1, 2);
    monitor_hit = 1;                       cyc(E_C0, 3);            // R3 armed mwait C1
    monitor_arm = 1;                       cyc(E_C0, 8);
    halt_req = 1;                          cyc(E_C1, 2);
    monitor_hit = 1;                       cyc(E_C1, 3);            // R3 halt C1 ignores monitor
    wake_init = 1;                         cyc(E_C0, 3);

    lvl_rd_req = 1; lvl_rd_idx = 2;        cyc(E_C2, 2);
    snoop_req = 1;                         cyc(E_SNP, 4);           // R4
    wake_smi = 1;                          cyc(E_SNP, 4);           // R4 wake ignored
    cyc(E_SNP, 4);
    snoop_done = 1;                        cyc(E_C2, 4);
    halt_req = 1; mwait_req = 1; mwait_hint = 3; cyc(E_C2, 12);     // R12 ignored outside C0
    wake_busint = 1; snoop_req = 1;        cyc(E_C0, 4);            // R4 wake wins
    mwait_req = 1; mwait_hint = 2;         cyc(E_C2, 2);
    wake_init = 1;                         cyc(E_C0, 4);

    lvl_rd_req = 1; lvl_rd_idx = 3; mwait_req = 1; mwait_hint = 2; halt_req = 1;
                                           cyc(E_FL, 12);           // R12 priority
    cyc(E_FL, 5);                                                   // R5 waits for ack
    flush_ack = 1;                         cyc(E_C3, 5);
    snoop_req = 1;                         cyc(E_C3, 7);            // R7
    cyc(E_C3, 7);
    wake_lint = 2'b01;                     cyc(E_C0, 8);            // R8

    monitor_arm = 1;                       cyc(E_C0, 8);
    mwait_req = 1; mwait_hint = 4;         cyc(E_FL, 2);
    flush_ack = 1;                         cyc(E_C4, 9);            // R9
    snoop_req = 1;                         cyc(E_C4, 7);            // R7
    monitor_hit = 1;                       cyc(E_C0, 8);            // R8 armed persists
    mwait_req = 1; mwait_hint = 4;         cyc(E_FL, 2);
    flush_ack = 1;                         cyc(E_C4, 9);
    monitor_hit = 1;                       cyc(E_C4, 8);            // R8 disarmed
    wake_busint = 1;                       cyc(E_C0, 8);

    lvl_rd_req = 1; lvl_rd_idx = 4;        cyc(E_FL, 2);
    wake_smi = 1; flush_ack = 1;           cyc(E_C0, 6);            // R6
    lvl_rd_req = 1; lvl_rd_idx = 3;        cyc(E_FL, 2);
    monitor_arm = 1;                       cyc(E_FL, 5);
    monitor_hit = 1;                       cyc(E_C0, 6);            // R6 monitor abort

    lvl_rd_req = 1; lvl_rd_idx = 3;        cyc(E_FL, 2);
    flush_ack = 1;                         cyc(E_C3, 5);
    core_reset = 1; halt_req = 1;          cyc(E_C0, 10);           // R10
    lvl_rd_req = 1; lvl_rd_idx = 4;        cyc(E_FL, 2);
    core_reset = 1; flush_ack = 1;         cyc(E_C0, 10);           // R10 over ack
    monitor_arm = 1;                       cyc(E_C0, 8);
    core_reset = 1;                        cyc(E_C0, 10);
    mwait_req = 1; mwait_hint = 1;         cyc(E_C1, 2);
    monitor_hit = 1;                       cyc(E_C1, 10);           // R10 disarmed
    wake_smi = 1;                          cyc(E_C0, 3);
    cyc(E_C0, 11);                                                  // R11

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule